// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block is the output stage of a sampling converter for the case where the converter makes its own serial data clock. Each finished conversion result is written into a holding register. A conversion-start strobe then launches a frame. The frame shifts the held word out on a single data line, most significant bit first. It is paced by exactly one burst of generated clock pulses, whose period comes from dividing the system clock. Because the strobe also starts the next conversion, the word sent in a frame is always the result of the conversion before it.

The output coding is chosen per frame. With the format input low, the stored two's complement word goes out unchanged. With it high, the word goes out as offset (straight) binary, which means the sign bit is inverted. An auxiliary tag bit is sampled together with the format at the start strobe. Once the last data bit has been sent, the data line parks at that captured tag level until the next frame begins. Between frames the generated clock rests low. A one-cycle completion pulse marks the end of each frame.

Result words enter through a valid/ready port. The block never applies back-pressure: ready goes high one cycle after reset is released and stays high. Every beat with valid high overwrites the holding register, and the latest beat before a start strobe is the one that gets sent. A beat that arrives during a frame does not disturb that frame and is sent in the next one.

Top module: `selfclk_result_tx`

## Requirements
- R1: Each accepted start produces exactly NBITS (default 16) pulses on `ser_clk`. Each pulse is high for HALF system cycles and low for HALF cycles, and the first rising edge comes HALF cycles after the start is sampled. Outside a frame `ser_clk` stays low.
- R2: Bits leave MSB first. The word sent is the holding-register content at the cycle the start is sampled. A result accepted during a frame is sent only by the following frame.
- R3: Each bit is on `ser_dat` before its pulse rises, and stays unchanged through that pulse's falling edge. It changes one system cycle after the fall.
- R4: `fmt_offset` is sampled at the start. When it is 0, the word is sent as stored (two's complement). When it is 1, bit NBITS-1 is inverted and the other bits are unchanged (straight binary).
- R5: One system cycle after the last falling edge, `ser_dat` equals `tag_in` as sampled at the start. Later changes of `tag_in` do not reach `ser_dat`, which holds that level until the next start.
- R6: `frame_done` is high for exactly one cycle, starting one system cycle after the last pulse falls.
- R7: A start strobe that arrives while a frame is in progress is ignored. The frame keeps its pulse count and its data, and no new frame follows it.
- R8: While reset is asserted, `ser_clk`, `ser_dat`, `frame_done` and `res_ready` are 0. The holding register resets to zero, so a frame started before any result arrives sends 0 (0x8000 in straight binary).
- R9: `res_ready` is 1 from the first cycle after reset is released onward. Every beat with `res_valid` high is accepted, and the last one before a start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result beat valid |
| res_data | input | NBITS | Conversion result, two's complement |
| res_ready | output | 1 | Result accepted (always high after reset) |
| conv_start | input | 1 | Conversion-start strobe, launches a frame when idle |
| fmt_offset | input | 1 | 0: two's complement, 1: straight binary |
| tag_in | input | 1 | Level for the data line after the frame |
| ser_clk | output | 1 | Generated serial data clock |
| ser_dat | output | 1 | Serial data, MSB first, then tag level |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
With HALF system cycles per half-period, the first rise is due HALF cycles after the start edge, and each rise follows the previous one by 2*HALF cycles. A data bit moves one cycle after its fall. The tag level and `frame_done` both appear one cycle after the last fall. The bench samples all outputs on the falling system-clock edge and keys each check on the transitions of `ser_clk` it has observed. It captures each bit at a rise, compares it at every high sample and at the fall, and counts the high length of each pulse. It counts the cycles from the last fall to `frame_done` and expects exactly one, then expects the pulse to be gone on the next sample.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/stx_clkgen.sv
module stx_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ser_clk,
  output logic fall_seen
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CLAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          sclk_q;
  logic          fall_q;
  logic          wrap;

  assign wrap = (cnt == CLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      fall_q <= wrap & sclk_q;
      if (wrap) begin
        cnt    <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ser_clk   = sclk_q;
  assign fall_seen = fall_q;

  initial begin
    a_r3_half_min: assert (HALF >= 2);
  end

  // R3: the shift strobe trails an actual falling edge by one cycle
  a_r3_fall_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!sclk_q && $past(sclk_q)));
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             fmt_offset,
  input  logic             tag,
  input  logic [NBITS-1:0] data_in,
  input  logic             shift,
  input  logic             sending,
  output logic             ser_dat
);
  logic [NBITS-1:0] shreg;
  logic             tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      tag_q <= 1'b0;
    end else if (load) begin
      shreg <= {data_in[NBITS-1] ^ fmt_offset, data_in[NBITS-2:0]};
      tag_q <= tag;
    end else if (shift) begin
      shreg <= {shreg[NBITS-2:0], 1'b0};
    end
  end

  assign ser_dat = sending ? shreg[NBITS-1] : tag_q;

  // R4: format choice touches only the top bit of the loaded word
  a_r4_load_format: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (shreg[NBITS-2:0] == $past(data_in[NBITS-2:0])) &&
             (shreg[NBITS-1] == ($past(data_in[NBITS-1]) ^ $past(fmt_offset))));

  // R5: captured tag changes only at a frame start
  a_r5_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(tag_q));
endmodule

// File: rtl/selfclk_result_tx.sv
module selfclk_result_tx
  import stx_pkg::*;
#(
  parameter int NBITS = 16,
  parameter int HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [NBITS-1:0] res_data,
  output logic             res_ready,
  input  logic             conv_start,
  input  logic             fmt_offset,
  input  logic             tag_in,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             frame_done
);
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IW-1:0] ILAST = IW'(NBITS - 1);

  tx_state_e        state;
  logic [IW-1:0]    bit_idx;
  logic [NBITS-1:0] hold_q;
  logic             ready_q;
  logic             done_q;
  logic             start_acc;
  logic             fall_seen;
  logic             last_bit;
  logic             step;

  assign start_acc = conv_start && (state == TX_IDLE);
  assign last_bit  = (bit_idx == ILAST);
  assign step      = (state == TX_SEND) && fall_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      ready_q <= 1'b1;
      if (res_valid && ready_q) hold_q <= res_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      bit_idx <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= step && last_bit;
      if (start_acc) begin
        state   <= TX_SEND;
        bit_idx <= '0;
      end else if (step) begin
        if (last_bit) state <= TX_IDLE;
        else          bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  stx_clkgen #(.HALF(HALF)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state == TX_SEND),
    .ser_clk   (ser_clk),
    .fall_seen (fall_seen)
  );

  stx_shifter #(.NBITS(NBITS)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_acc),
    .fmt_offset (fmt_offset),
    .tag        (tag_in),
    .data_in    (hold_q),
    .shift      (step && !last_bit),
    .sending    (state == TX_SEND),
    .ser_dat    (ser_dat)
  );

  assign res_ready  = ready_q;
  assign frame_done = done_q;

  // R1: generated clock rests low outside a frame
  a_r1_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE) |-> !ser_clk);

  // R6: done comes exactly one cycle after a falling edge of ser_clk
  a_r6_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!$past(ser_clk) && $past(ser_clk, 2)));

  // R6: done never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7: a start during a frame does not restart it
  a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TX_SEND) && conv_start && !fall_seen) |=>
      ((state == TX_SEND) && $stable(bit_idx)));

  // R5: data line frozen between frames
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == TX_IDLE) && $past(state == TX_IDLE)) |-> $stable(ser_dat));

  // R9: once up, ready never drops
  a_r9_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |=> res_ready);
endmodule

// File: tb/selfclk_result_tx_bench.sv
module selfclk_result_tx_bench;
  localparam int NB = 16;
  localparam int H  = 2;
  localparam int NV = 6;
  // each entry: {result, fmt_offset, tag}
  localparam logic [17:0] VEC [NV] = '{
    {16'h1234, 1'b0, 1'b1},
    {16'h8000, 1'b1, 1'b0},
    {16'h7FFF, 1'b1, 1'b1},
    {16'hFFFF, 1'b0, 1'b0},
    {16'hA5C3, 1'b1, 1'b1},
    {16'h0001, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_valid = 1'b0;
  logic [NB-1:0] res_data = '0;
  logic          res_ready;
  logic          conv_start = 1'b0;
  logic          fmt_offset = 1'b0;
  logic          tag_in = 1'b0;
  logic          ser_clk;
  logic          ser_dat;
  logic          frame_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  selfclk_result_tx #(.NBITS(NB), .HALF(H)) u_selfclk_result_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_ready  (res_ready),
    .conv_start (conv_start),
    .fmt_offset (fmt_offset),
    .tag_in     (tag_in),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .frame_done (frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_result(input logic [NB-1:0] d);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // Launch a frame and watch it; mid_start / mid_load inject stimulus during it.
  task automatic run_frame(input logic [NB-1:0] exp_word, input logic exp_tag,
                           input bit mid_start, input bit mid_load,
                           input logic [NB-1:0] mid_word);
    int rises = 0;
    int unstable = 0;
    int bad_hi = 0;
    int hcount = 0;
    int since_fall = -1;
    int cyc = 0;
    int gap = -1;
    bit seen_done = 1'b0;
    logic prev = 1'b0;
    logic curbit = 1'b0;
    logic [NB-1:0] got = '0;
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    prev = ser_clk;
    while (!seen_done && cyc < 60 * H * NB) begin
      if (cyc == 3) tag_in = ~exp_tag;
      if (mid_start && cyc == 9 * H) conv_start = 1'b1;
      if (mid_start && cyc == 9 * H + 1) conv_start = 1'b0;
      if (mid_load && cyc == 5 * H) begin res_valid = 1'b1; res_data = mid_word; end
      if (mid_load && cyc == 5 * H + 1) res_valid = 1'b0;
      @(negedge clk);
      cyc++;
      if (!prev && ser_clk) begin
        got = {got[NB-2:0], ser_dat};
        curbit = ser_dat;
        rises++;
        hcount = 1;
      end else if (prev && ser_clk) begin
        hcount++;
        if (ser_dat !== curbit) unstable++;
      end else if (prev && !ser_clk) begin
        if (ser_dat !== curbit) unstable++;
        if (hcount != H) bad_hi++;
        since_fall = 0;
      end else if (since_fall >= 0) begin
        since_fall++;
      end
      prev = ser_clk;
      if (frame_done) begin
        seen_done = 1'b1;
        gap = since_fall;
      end
    end
    check(seen_done, "R6 done seen", seen_done, 1);
    check(rises == NB, "R1 pulse count", rises, NB);
    check(bad_hi == 0, "R1 high length", bad_hi, 0);
    check(got == exp_word, "R2/R4 word", got, exp_word);
    check(unstable == 0, "R3 bit stability", unstable, 0);
    check(gap == 1, "R6 done delay", gap, 1);
    check(ser_dat === exp_tag, "R5 tag after frame", ser_dat, exp_tag);
    @(negedge clk);
    check(frame_done == 1'b0, "R6 done width", frame_done, 0);
  endtask

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    check(ser_clk == 1'b0 && ser_dat == 1'b0 && frame_done == 1'b0 && res_ready == 1'b0,
          "R8 reset outputs", {ser_clk, ser_dat, frame_done, res_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_ready == 1'b1, "R9 ready after reset", res_ready, 1);

    // R8 frame before any result: zero word, straight binary
    fmt_offset = 1'b1;
    tag_in = 1'b1;
    run_frame(16'h8000, 1'b1, 1'b0, 1'b0, '0);

    // vector table walk: R2 R4 R5 R1 R3 R6
    for (int i = 0; i < NV; i++) begin
      load_result(VEC[i][17:2]);
      fmt_offset = VEC[i][1];
      tag_in = VEC[i][0];
      run_frame({VEC[i][17] ^ VEC[i][1], VEC[i][16:2]}, VEC[i][0], 1'b0, 1'b0, '0);
    end

    // R9 last beat wins
    load_result(16'h1111);
    load_result(16'h4C2D);
    fmt_offset = 1'b0;
    tag_in = 1'b0;
    run_frame(16'h4C2D, 1'b0, 1'b0, 1'b0, '0);

    // R2 result landing mid-frame goes to the next frame
    load_result(16'h3A5A);
    tag_in = 1'b1;
    run_frame(16'h3A5A, 1'b1, 1'b0, 1'b1, 16'hC0DE);
    tag_in = 1'b0;
    run_frame(16'hC0DE, 1'b0, 1'b0, 1'b0, '0);

    // R7 start during a frame ignored
    load_result(16'h6B09);
    tag_in = 1'b1;
    run_frame(16'h6B09, 1'b1, 1'b1, 1'b0, '0);
    begin
      int edges = 0;
      logic lvl;
      lvl = ser_dat;
      for (int k = 0; k < 12 * H; k++) begin
        @(negedge clk);
        if (ser_clk || ser_dat !== lvl) edges++;
      end
      check(edges == 0, "R7 no restart, R1 idle low", edges, 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule